// File: doc/BRIEF.md
# Multi-Mode Logarithmic Shifter

This block is a purely combinational shifter for a datapath word. The shift amount is applied through a chain of two-way multiplexer stages. Stage k handles amount bit k. It either moves the word by 2^k positions or passes it through unchanged. An 8-bit word therefore needs three stages, and a 32-bit word needs five. This replaces a flat truth-table decode whose size grows with the product of data and amount combinations.

A two-bit mode input selects one of three fill behaviours on the same stage chain: a shift toward the most significant end with zero fill, a right shift with zero fill, or a right shift that copies the sign bit into the vacated positions. The fill bit is worked out once from the mode and the input's top bit, and every stage uses that same bit. The output follows the inputs in the same cycle. There is no clock, state or handshake.

Top module: `barrel_shifter`

## Requirements
- R1: Stage k (k = 0 for the least significant amount bit) moves the word by exactly 2^k positions when amount bit k is 1 and leaves it unchanged when that bit is 0. For 8-bit data the three stages move by 1, 2 and 4.
- R2: With an amount of zero the output equals the input in every mode.
- R3: Mode 2'b00 shifts toward the most significant end. Bits leaving the top are lost and zeros enter at bit 0. For example, 8'b10010001 by 2 gives 8'b01000100.
- R4: Mode 2'b01 shifts toward bit 0 and fills the vacated top positions with zeros. For example, 8'b10010001 by 3 gives 8'b00010010.
- R5: Mode 2'b10 shifts toward bit 0 and fills the vacated top positions with copies of input bit WIDTH-1. For example, 8'b10010001 by 3 gives 8'b11110010.
- R6: Mode 2'b11 behaves exactly like mode 2'b01.
- R7: At the largest amount (WIDTH-1), the results are as follows. Mode 2'b00 leaves only input bit 0, placed at the top. Mode 2'b01 leaves only input bit WIDTH-1, placed at bit 0. Mode 2'b10 gives a word made entirely of copies of input bit WIDTH-1.
- R8: The output depends only on the present inputs and settles without any clock edge.
- R9: With WIDTH = 32 the amount input is 5 bits wide, and R2 to R7 hold for all 32 amounts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH (8) | Word to be shifted |
| amt | input | log2(WIDTH) (3) | Shift distance |
| mode | input | 2 | 00 toward MSB, 01 or 11 right with zero fill, 10 right with sign fill |
| dout | output | WIDTH (8) | Shifted word |

## Verification
At 8 bits, every data word is driven with every amount in every mode. This separates stage-ordering faults: a stage wired to the wrong amount bit gives a wrong result for the single-bit amounts 1, 2 and 4. It also separates fill faults: words with the top bit clear and set give different results only in sign-fill mode. Mode 11 is compared against the zero-fill right result, so a decode that folds it into sign fill is caught. A second instance at 32 bits is driven with alternating, single-one, all-ones and sign-set words across all 32 amounts. This shows that the generated stage count and the derived amount width follow the parameter.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        MODE_TOWARD_MSB = 2'b00,
        MODE_ZERO_RIGHT = 2'b01,
        MODE_SIGN_RIGHT = 2'b10,
        MODE_ALT_RIGHT  = 2'b11
    } shf_mode_t;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shf_dir_t;

    typedef struct packed {
        shf_dir_t dir;
        logic     fill;
    } shf_ctrl_t;

    function automatic shf_ctrl_t decode_mode(input shf_mode_t m, input logic msb);
        shf_ctrl_t c;
        c.dir  = (m == MODE_TOWARD_MSB) ? DIR_LEFT : DIR_RIGHT;
        c.fill = (m == MODE_SIGN_RIGHT) ? msb : 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
    import shf_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       msb,
    output shf_ctrl_t  ctrl
);
    shf_mode_t mode_e;

    always_comb begin
        mode_e = shf_mode_t'(mode);
        ctrl   = decode_mode(mode_e, msb);
    end

endmodule

// File: rtl/shf_stage.sv
module shf_stage
    import shf_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    input  shf_ctrl_t        ctrl,
    output logic [WIDTH-1:0] dout
);
    always_comb begin
        if (!en) begin
            dout = din;
        end else if (ctrl.dir == DIR_LEFT) begin
            dout = {din[WIDTH-1-DIST:0], {DIST{1'b0}}};
        end else begin
            dout = {{DIST{ctrl.fill}}, din[WIDTH-1:DIST]};
        end
    end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
    import shf_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] dout
);
    localparam int STAGES = AMT_W;

    shf_ctrl_t        ctrl;
    logic [WIDTH-1:0] chain [0:STAGES];

    shf_ctrl u_ctrl (
        .mode (mode),
        .msb  (din[WIDTH-1]),
        .ctrl (ctrl)
    );

    assign chain[0] = din;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        shf_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << k)
        ) u_stage (
            .din  (chain[k]),
            .en   (amt[k]),
            .ctrl (ctrl),
            .dout (chain[k+1])
        );
    end

    assign dout = chain[STAGES];

    always_comb begin
        if (!$isunknown({din, amt, mode})) begin
            AST_ZERO_PASS: assert (amt != '0 || dout == din) else $error("zero amount altered word"); // R2
            AST_LSB_ZERO_FILL: assert (mode != 2'b00 || amt == '0 || dout[0] == 1'b0) else $error("low bit not zero"); // R3
            AST_NO_NEW_ONES: assert (mode != 2'b00 || $countones(dout) <= $countones(din)) else $error("ones created"); // R3
            AST_TOP_ZERO_FILL: assert (!(mode == 2'b01 || mode == 2'b11) || amt == '0 || dout[WIDTH-1] == 1'b0) else $error("top bit not zero"); // R4
            AST_SIGN_KEPT: assert (mode != 2'b10 || dout[WIDTH-1] == din[WIDTH-1]) else $error("sign lost"); // R5
        end
    end

endmodule

// File: tb/sim_barrel_shifter.sv
module sim_barrel_shifter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [7:0]  d8  = '0;
    logic [2:0]  a8  = '0;
    logic [1:0]  m8  = '0;
    logic [7:0]  q8;
    logic [31:0] d32 = '0;
    logic [4:0]  a32 = '0;
    logic [1:0]  m32 = '0;
    logic [31:0] q32;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    barrel_shifter #(.WIDTH(8)) u0 (.din(d8), .amt(a8), .mode(m8), .dout(q8));
    barrel_shifter #(.WIDTH(32)) u1 (.din(d32), .amt(a32), .mode(m32), .dout(q32));

    function automatic logic [31:0] ref_shift(int w, logic [31:0] d, int a, logic [1:0] m);
        logic [31:0] mask;
        logic [31:0] r;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        d = d & mask;
        case (m)
            2'b00: r = (d << a) & mask;
            2'b10: begin
                r = d >> a;
                if (d[w-1]) for (int i = w - a; i < w; i++) r[i] = 1'b1;
            end
            default: r = d >> a;
        endcase
        return r;
    endfunction

    function automatic string pick_tag(int w, int a, logic [1:0] m);
        if (w == 32) return "R9";
        if (a == 0) return "R2";
        if (a == w - 1) return "R7";
        if (m == 2'b00 && (a == 1 || a == 2 || a == 4)) return "R1";
        case (m)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        chk("R2", {24'd0, q8}, 32'd0);

        // Named examples: R3, R4, R5, R6
        @(posedge clk); d8 <= 8'b10010001; a8 <= 3'd2; m8 <= 2'b00;
        @(negedge clk); chk("R3", {24'd0, q8}, 32'h44);
        @(posedge clk); a8 <= 3'd3; m8 <= 2'b01;
        @(negedge clk); chk("R4", {24'd0, q8}, 32'h12);
        @(posedge clk); m8 <= 2'b10;
        @(negedge clk); chk("R5", {24'd0, q8}, 32'hF2);
        @(posedge clk); m8 <= 2'b11;
        @(negedge clk); chk("R6", {24'd0, q8}, 32'h12);

        // R8: change inputs between clock edges, output follows at once
        d8 = 8'h0F; a8 = 3'd1; m8 = 2'b00;
        #1 chk("R8", {24'd0, q8}, 32'h1E);
        d8 = 8'h80; m8 = 2'b10;
        #1 chk("R8", {24'd0, q8}, 32'hC0);

        // exhaustive at 8 bits: R1..R7
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 8; a++) begin
                for (int d = 0; d < 256; d++) begin
                    @(posedge clk);
                    d8 <= 8'(d); a8 <= 3'(a); m8 <= 2'(m);
                    @(negedge clk);
                    chk(pick_tag(8, a, 2'(m)), {24'd0, q8},
                        ref_shift(8, 32'(d), a, 2'(m)));
                end
            end
        end

        // R9: 32-bit instance, all amounts and modes
        for (int p = 0; p < 6; p++) begin
            logic [31:0] pat;
            case (p)
                0: pat = 32'hAAAA_5555;
                1: pat = 32'h0000_0001;
                2: pat = 32'hFFFF_FFFF;
                3: pat = 32'h8000_0000;
                4: pat = 32'h9123_4567;
                default: pat = 32'h7FFF_FFFE;
            endcase
            for (int m = 0; m < 4; m++) begin
                for (int a = 0; a < 32; a++) begin
                    @(posedge clk);
                    d32 <= pat; a32 <= 5'(a); m32 <= 2'(m);
                    @(negedge clk);
                    chk("R9", q32, ref_shift(32, pat, a, 2'(m)));
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule